// File: doc/BRIEF.md
# Symbol Serializer with NRZI Line Encoding

This block is the transmit end of a 100 Mb/s physical-layer path. It accepts a 5-bit code group in parallel once every five cycles of a single bit-rate clock (125 MHz) and shifts it out one bit per cycle, so the symbol rate is one fifth of the bit rate (25 MHz). Each serial bit is then NRZI-coded before it reaches the line pin: a one flips the line level and a zero leaves it where it was.

The symbol strobe comes from an internal divide-by-five counter. Upstream logic watches the strobe and presents the next symbol on `sym_in` while it is high. Symbols follow one another with no idle bit between them. A transmit-enable input switches the encoder off. While it is off, the line level is frozen, but the shifter keeps consuming symbols. A loopback input sends the encoded stream to a separate receive-side output and keeps the line pin quiet.

Top module: `sym_ser_nrzi_tx`

## Requirements
- R1: During and right after a synchronous active-high `rst`, `line_out` and `loop_out` are 0 and `sym_strobe` is 1. The first cycle after reset is therefore a capture cycle.
- R2: `sym_strobe` is high in exactly one cycle out of every five, with four low cycles between two high cycles.
- R3: `sym_in` is captured at the clock edge that ends a cycle in which `sym_strobe` is high. Its value in any other cycle has no effect on the outputs.
- R4: A captured symbol is sent bit 4 first, then bits 3, 2, 1 and 0, one per cycle, in the five cycles after capture. The next symbol follows directly after bit 0.
- R5: With `tx_en` high, each serial bit of 1 inverts the encoded level at the next edge, and each bit of 0 keeps it.
- R6: With `tx_en` low, the encoded level holds its value. Serial bits are still consumed and are lost. When `tx_en` rises again, encoding resumes from the held level.
- R7: With `loop_en` high, `loop_out` carries the encoded level and `line_out` is 0. With `loop_en` low, `line_out` carries the level and `loop_out` is 0.
- R8: A change of `tx_en` or `loop_en` in a capture cycle affects only the edge at which the last bit of the old symbol is encoded. It does not disturb the symbol being captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_in | input | 5 | Parallel code group, sampled in the strobe cycle |
| tx_en | input | 1 | Encoder enable; low freezes the line level |
| loop_en | input | 1 | Routes the encoded stream to `loop_out` instead of `line_out` |
| sym_strobe | output | 1 | High in the cycle in which `sym_in` is captured |
| line_out | output | 1 | NRZI line output |
| loop_out | output | 1 | NRZI stream returned toward the receive side |

## Verification
Two events share the capture edge: the shifter loads a new symbol, and the NRZI state encodes the last bit of the previous symbol. A broken handoff at that edge shows up as a lost or repeated bit. The bench drives one random symbol per period and also changes `sym_in` in non-strobe cycles. In a separate phase it toggles `tx_en` and `loop_en` exactly in strobe cycles, so each control change coincides with a capture. A queue-based bit model decides whether the final bit was encoded under the old or the new control value, and both output pins are compared against it on every cycle.

// File: rtl/sym_ser_pkg.sv
package sym_ser_pkg;

    localparam int SYM_BITS = 5;

    typedef logic [SYM_BITS-1:0] sym_t;

    typedef struct packed {
        logic line;
        logic loop;
    } tx_pins_t;

    // Next NRZI level: a one flips the level, a zero keeps it; disabled holds.
    function automatic logic nrzi_step(input logic level, input logic bit_in,
                                       input logic enable);
        return enable ? (level ^ bit_in) : level;
    endfunction

    // Steer the encoded level to exactly one of the two pins.
    function automatic tx_pins_t route_level(input logic level, input logic loopback);
        tx_pins_t p;
        p.line = loopback ? 1'b0 : level;
        p.loop = loopback ? level : 1'b0;
        return p;
    endfunction

endpackage

// File: rtl/sym_phase_gen.sv
module sym_phase_gen #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst,
    output logic strobe
);
    localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign strobe = (phase == '0);
endmodule

// File: rtl/sym_shifter.sv
module sym_shifter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] par_in,
    output logic         ser_bit
);
    logic [W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= par_in;
        end else begin
            shreg <= {shreg[W-2:0], 1'b0};
        end
    end

    // Most significant bit leaves first.
    assign ser_bit = shreg[W-1];
endmodule

// File: rtl/nrzi_encoder.sv
module nrzi_encoder
    import sym_ser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic bit_in,
    output logic level
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
        end else begin
            level <= nrzi_step(level, bit_in, enable);
        end
    end
endmodule

// File: rtl/sym_ser_nrzi_tx.sv
module sym_ser_nrzi_tx
    import sym_ser_pkg::*;
#(
    parameter int SYM_W = SYM_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] sym_in,
    input  logic             tx_en,
    input  logic             loop_en,
    output logic             sym_strobe,
    output logic             line_out,
    output logic             loop_out
);
    logic     ser_bit;
    logic     enc_level;
    tx_pins_t pins;

    sym_phase_gen #(.DIV(SYM_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .strobe (sym_strobe)
    );

    sym_shifter #(.W(SYM_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (sym_strobe),
        .par_in  (sym_in),
        .ser_bit (ser_bit)
    );

    nrzi_encoder u_enc (
        .clk    (clk),
        .rst    (rst),
        .enable (tx_en),
        .bit_in (ser_bit),
        .level  (enc_level)
    );

    always_comb begin
        pins     = route_level(enc_level, loop_en);
        line_out = pins.line;
        loop_out = pins.loop;
    end
endmodule

// File: rtl/sym_ser_nrzi_chk.sv
module sym_ser_nrzi_chk #(
    parameter int DIV = 5
) (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic loop_en,
    input logic sym_strobe,
    input logic line_out,
    input logic loop_out,
    input logic nrz_bit
);
    int gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= DIV - 1;
        end else if (sym_strobe) begin
            gap <= 0;
        end else begin
            gap <= gap + 1;
        end
    end

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sym_strobe && !line_out && !loop_out));

    // R2
    strobe_period_chk: assert property (@(posedge clk) disable iff (rst)
        sym_strobe == (gap == DIV - 1));

    // R5
    toggle_on_one_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !loop_en && nrz_bit) |=> (loop_en || line_out != $past(line_out)));

    // R5
    hold_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !loop_en && !nrz_bit) |=> (loop_en || $stable(line_out)));

    // R6
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !loop_en) |=> (loop_en || $stable(line_out)));

    // R7
    one_pin_only_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({line_out, loop_out}));
endmodule

bind sym_ser_nrzi_tx sym_ser_nrzi_chk #(.DIV(SYM_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .loop_en    (loop_en),
    .sym_strobe (sym_strobe),
    .line_out   (line_out),
    .loop_out   (loop_out),
    .nrz_bit    (ser_bit)
);

// File: tb/sym_ser_nrzi_tx_tb.sv
module sym_ser_nrzi_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] sym_in;
    logic       tx_en;
    logic       loop_en;
    logic       sym_strobe;
    logic       line_out;
    logic       loop_out;

    int    total = 0;
    int    bad = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    // Reference model state
    bit q[$];
    int mph = 0;
    bit mlvl = 1'b0;

    always #4 clk = ~clk;

    sym_ser_nrzi_tx dut_i (
        .clk        (clk),
        .rst        (rst),
        .sym_in     (sym_in),
        .tx_en      (tx_en),
        .loop_en    (loop_en),
        .sym_strobe (sym_strobe),
        .line_out   (line_out),
        .loop_out   (loop_out)
    );

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            mph  = 0;
            mlvl = 1'b0;
        end else begin
            bit b;
            b = (q.size() > 0) ? q.pop_front() : 1'b0;
            if (tx_en) mlvl = mlvl ^ b;
            if (mph == 0) begin
                for (int i = 4; i >= 0; i--) q.push_back(sym_in[i]);
            end
            mph = (mph + 1) % 5;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!finished) begin
            check("R2", sym_strobe, (mph == 0));
            check(tag, line_out, loop_en ? 1'b0 : mlvl);
            check("R7", loop_out, loop_en ? mlvl : 1'b0);
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sym_in = '0; tx_en = 1'b1; loop_en = 1'b0;
        tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: first cycle after reset
        @(negedge clk);
        // R4: fixed patterns expose bit order
        tag = "R4";
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (mph == 0) sym_in = (k < 20) ? 5'b10000 : 5'b00011;
        end
        // R3: sym_in scrambled in every cycle, only strobe cycles count
        tag = "R3";
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            sym_in = 5'($urandom);
        end
        // R5: random symbols, encoder on
        tag = "R5";
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (mph == 0) sym_in = 5'($urandom);
        end
        // R6: encoder switched off and on at arbitrary cycles
        tag = "R6";
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            sym_in = 5'($urandom);
            if (k % 7 == 0) tx_en = ~tx_en;
        end
        tx_en = 1'b1;
        // R7: loopback toggled at arbitrary cycles
        tag = "R7";
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            sym_in = 5'($urandom);
            if (k % 11 == 0) loop_en = ~loop_en;
        end
        // R8: controls change exactly in capture cycles
        tag = "R8";
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            sym_in = 5'($urandom);
            if (mph == 0) begin
                tx_en   = $urandom_range(0, 1);
                loop_en = $urandom_range(0, 1);
            end
        end
        // R1: reset in mid-stream
        tag = "R1";
        @(negedge clk);
        rst = 1'b1; loop_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0; tx_en = 1'b1;
        tag = "R5";
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (mph == 0) sym_in = 5'($urandom);
        end
        @(negedge clk);
        #2;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule